// File: doc/BRIEF.md
# Byte/Word Shift and Rotate Engine

This block shifts or rotates an 8-bit or 16-bit operand by a count between 0 and 31. It advances one bit position per clock. A request is accepted with a single-cycle `start` pulse. The engine then runs until its final step and signals completion with a one-cycle `done` pulse. The block returns the new operand value, a five-flag vector and a mask that marks which flags the selected operation updates. Flags outside the mask are passed through from the incoming flag vector. The caller can therefore write `flags_out` straight back to its status register.

There are seven operations:
- logical left shift, which also serves as the arithmetic left shift;
- logical right shift;
- arithmetic right shift;
- plain rotate left and plain rotate right;
- rotate left and rotate right through carry, where the carry flag is an extra bit in the ring.

The caller selects the operand and the count. The result and flags stay stable from `done` until the next accepted `start`.

Top module: `sr_unit`

## Requirements
- R1: Op code 0 (left shift): on every step the operand's top bit (bit 15 in word mode, bit 7 in byte mode) goes into carry and a zero enters bit 0; the mask marks CF, OF, PF, SF and ZF.
- R2: Op code 1 (logical right shift): on every step bit 0 goes into carry and a zero enters the top bit; the mask marks CF, OF, PF, SF and ZF.
- R3: Op code 2 (arithmetic right shift): on every step bit 0 goes into carry while the top bit keeps its value; the mask marks CF, PF, SF and ZF, and OF is passed through unchanged.
- R4: Op codes 3 and 4 (plain rotate left / right): the bit leaving one end enters both the carry and the other end, so the count of ones is preserved; the mask marks only CF and OF.
- R5: Op codes 5 and 6 (rotate left / right through carry): the leaving bit goes into carry and the previous carry enters the other end, forming a 9-bit or 17-bit ring; the mask marks CF, OF, PF, SF and ZF.
- R6: A count of zero, or op code 7, returns the operand unchanged, sets the mask to zero and copies every incoming flag to the output, with `done` at the edge that accepts `start`.
- R7: For a count of one, OF is set as follows:
  - left shift, rotate left and rotate left through carry: OF is the new top bit XOR the new carry;
  - logical right shift: OF is the original top bit;
  - rotate right and rotate right through carry: OF is the XOR of the two highest result bits.

  For counts above one, OF keeps its incoming value.
- R8: PF is 1 when the low byte of the result has an even number of ones; SF is the result's top bit for the selected size; ZF is 1 when the result is zero at the selected size.
- R9: Byte mode (`wide` = 0) ignores operand bits 15:8 and drives result bits 15:8 to zero.
- R10: When `start` is accepted at clock edge k with a count N of 1 or more, `busy` is high after edges k through k+N-1. `done` is high for exactly the one cycle after edge k+N. A `start` that arrives while `busy` is high is ignored.
- R11: Flag vectors use bit 0 = CF, bit 1 = OF, bit 2 = PF, bit 3 = SF, bit 4 = ZF. A flag whose mask bit is 0 is copied from `flags_in` to `flags_out`.
- R12: After reset, `busy` and `done` are low, `result` is zero and `flag_upd` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted when not busy |
| op | input | 3 | Operation code (0..7) |
| wide | input | 1 | 1 = word operand, 0 = byte operand |
| operand | input | 16 | Value to shift or rotate |
| count | input | 5 | Number of bit positions, 0..31 |
| flags_in | input | 5 | Incoming flags {ZF,SF,PF,OF,CF} |
| busy | output | 1 | Engine is stepping |
| done | output | 1 | One-cycle completion pulse |
| result | output | 16 | Shifted or rotated value |
| flags_out | output | 5 | Outgoing flags {ZF,SF,PF,OF,CF} |
| flag_upd | output | 5 | Mask of flags the operation updates |

## Verification
The bench targets the following faults, with the visible symptom of each:
- **Through-carry ring.** A rotate through carry by nine positions in byte mode must bring the operand and carry back to where they started. A design that dropped the carry from the ring would return a different byte.
- **Arithmetic right shift.** The sign bit must be replicated, and OF must stay untouched. A design that filled with zero would clear the top bits, and one that included OF in the mask would mark OF as updated.
- **Count of zero and op code 7.** These must finish in one cycle with all flags passed through. A design that treated them like a count of 32 would finish late or alter the operand.
- **One-bit OF rules.** These are probed with patterns where the new top bit and the carry differ, exposing a swapped or missing XOR.
- **Ignored start.** A second `start` pulsed mid-run must not disturb the first result or cause a stray second `done`.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic [2:0] {
    OP_SHL  = 3'd0,
    OP_SHR  = 3'd1,
    OP_SAR  = 3'd2,
    OP_ROL  = 3'd3,
    OP_ROR  = 3'd4,
    OP_RCL  = 3'd5,
    OP_RCR  = 3'd6,
    OP_NONE = 3'd7
  } sr_op_e;

  localparam int FLAG_W = 5;
  localparam int FL_CF  = 0;
  localparam int FL_OF  = 1;
  localparam int FL_PF  = 2;
  localparam int FL_SF  = 3;
  localparam int FL_ZF  = 4;

  // Which flags each operation writes.
  function automatic logic [FLAG_W-1:0] upd_mask(input sr_op_e op);
    logic [FLAG_W-1:0] m;
    case (op)
      OP_SHL, OP_SHR, OP_RCL, OP_RCR: m = 5'b11111;
      OP_SAR:                         m = 5'b11101;
      OP_ROL, OP_ROR:                 m = 5'b00011;
      default:                        m = 5'b00000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sr_ctrl.sv
module sr_ctrl #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] count,
  input  logic             skip,
  output logic             load,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] rem_q;
  logic             busy_q;
  logic             done_q;
  logic             zero_run;
  logic             last_step;

  assign load      = start & ~busy_q;
  assign zero_run  = skip | (count == '0);
  assign last_step = busy_q && (rem_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load) begin
        if (zero_run) begin
          done_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          rem_q  <= count;
        end
      end else if (busy_q) begin
        rem_q <= rem_q - CNT_W'(1);
        if (last_step) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R10: completion never overlaps with stepping
  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R10: the engine stays busy until its remaining count reaches one
  assert_busy_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && rem_q != CNT_W'(1)) |=> busy);

  // R10: the remaining count is never zero while stepping
  assert_rem_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> rem_q != '0);

  // R6: a zero-length request completes at the next edge
  assert_zero_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && zero_run) |=> (done && !busy));

endmodule

// File: rtl/sr_step.sv
module sr_step
  import sr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  sr_op_e            op,
  input  logic              wide,
  input  logic [DATA_W-1:0] d,
  input  logic              cf,
  output logic [DATA_W-1:0] d_nxt,
  output logic              cf_nxt
);

  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] size_mask(input logic w);
    return w ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
  endfunction

  // Places bit b at the top position of the selected size.
  function automatic logic [DATA_W-1:0] put_top(input logic w, input logic b);
    logic [DATA_W-1:0] v;
    v = '0;
    if (w) v[DATA_W-1] = b;
    else   v[HALF_W-1] = b;
    return v;
  endfunction

  logic              msb;
  logic              lsb;
  logic [DATA_W-1:0] up;
  logic [DATA_W-1:0] dn;

  always_comb begin
    msb = wide ? d[DATA_W-1] : d[HALF_W-1];
    lsb = d[0];
    up  = (d << 1) & size_mask(wide);
    dn  = d >> 1;
    case (op)
      OP_SHL: begin d_nxt = up;                        cf_nxt = msb; end
      OP_SHR: begin d_nxt = dn;                        cf_nxt = lsb; end
      OP_SAR: begin d_nxt = dn | put_top(wide, msb);   cf_nxt = lsb; end
      OP_ROL: begin d_nxt = up | DATA_W'(msb);         cf_nxt = msb; end
      OP_ROR: begin d_nxt = dn | put_top(wide, lsb);   cf_nxt = lsb; end
      OP_RCL: begin d_nxt = up | DATA_W'(cf);          cf_nxt = msb; end
      OP_RCR: begin d_nxt = dn | put_top(wide, cf);    cf_nxt = lsb; end
      default: begin d_nxt = d;                        cf_nxt = cf;  end
    endcase
  end

  // R5: a through-carry step neither creates nor loses a one across the ring
  assert_ring_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == OP_RCL || op == OP_RCR)) |->
      ($countones(d_nxt) + int'(cf_nxt) == $countones(d) + int'(cf)));

endmodule

// File: rtl/sr_flags.sv
module sr_flags
  import sr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  sr_op_e            op,
  input  logic              wide,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] data,
  input  logic              cf,
  input  logic              orig_msb,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_out,
  output logic [FLAG_W-1:0] flag_upd
);

  localparam int HALF_W = DATA_W / 2;

  function automatic logic even_parity(input logic [HALF_W-1:0] b);
    return ~^b;
  endfunction

  function automatic logic one_bit_of(input sr_op_e o, input logic top,
                                      input logic next, input logic c,
                                      input logic om, input logic prev);
    case (o)
      OP_SHL, OP_ROL, OP_RCL: return top ^ c;
      OP_SHR:                 return om;
      OP_ROR, OP_RCR:         return top ^ next;
      default:                return prev;
    endcase
  endfunction

  logic              skip;
  logic              top;
  logic              next;
  logic [FLAG_W-1:0] vec;

  always_comb begin
    skip = (op == OP_NONE) || (count == '0);
    top  = wide ? data[DATA_W-1] : data[HALF_W-1];
    next = wide ? data[DATA_W-2] : data[HALF_W-2];
    vec        = '0;
    vec[FL_CF] = cf;
    vec[FL_PF] = even_parity(data[HALF_W-1:0]);
    vec[FL_SF] = top;
    vec[FL_ZF] = wide ? (data == '0) : (data[HALF_W-1:0] == '0);
    vec[FL_OF] = (count == CNT_W'(1))
               ? one_bit_of(op, top, next, cf, orig_msb, flags_in[FL_OF])
               : flags_in[FL_OF];
    flag_upd  = skip ? '0 : upd_mask(op);
    flags_out = (vec & flag_upd) | (flags_in & ~flag_upd);
  end

endmodule

// File: rtl/sr_unit.sv
module sr_unit
  import sr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        op,
  input  logic              wide,
  input  logic [DATA_W-1:0] operand,
  input  logic [CNT_W-1:0]  count,
  input  logic [4:0]        flags_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic [4:0]        flags_out,
  output logic [4:0]        flag_upd
);

  localparam int HALF_W = DATA_W / 2;

  function automatic logic [DATA_W-1:0] trim(input logic w, input logic [DATA_W-1:0] v);
    return w ? v : {{(DATA_W-HALF_W){1'b0}}, v[HALF_W-1:0]};
  endfunction

  sr_op_e            op_in;
  sr_op_e            op_q;
  logic              wide_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [FLAG_W-1:0] fin_q;
  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] data_q;
  logic              cf_q;
  logic [DATA_W-1:0] data_nxt;
  logic              cf_nxt;
  logic              load;
  logic              orig_msb;

  assign op_in = sr_op_e'(op);

  sr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .count (count),
    .skip  (op_in == OP_NONE),
    .load  (load),
    .busy  (busy),
    .done  (done)
  );

  sr_step #(.DATA_W(DATA_W)) u_step (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (busy),
    .op     (op_q),
    .wide   (wide_q),
    .d      (data_q),
    .cf     (cf_q),
    .d_nxt  (data_nxt),
    .cf_nxt (cf_nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_NONE;
      wide_q <= 1'b1;
      cnt_q  <= '0;
      fin_q  <= '0;
      opnd_q <= '0;
      data_q <= '0;
      cf_q   <= 1'b0;
    end else if (load) begin
      op_q   <= op_in;
      wide_q <= wide;
      cnt_q  <= count;
      fin_q  <= flags_in;
      opnd_q <= trim(wide, operand);
      data_q <= trim(wide, operand);
      cf_q   <= flags_in[FL_CF];
    end else if (busy) begin
      data_q <= data_nxt;
      cf_q   <= cf_nxt;
    end
  end

  assign orig_msb = wide_q ? opnd_q[DATA_W-1] : opnd_q[HALF_W-1];

  sr_flags #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_flags (
    .op        (op_q),
    .wide      (wide_q),
    .count     (cnt_q),
    .data      (data_q),
    .cf        (cf_q),
    .orig_msb  (orig_msb),
    .flags_in  (fin_q),
    .flags_out (flags_out),
    .flag_upd  (flag_upd)
  );

  assign result = data_q;

  // R4: a finished plain rotate keeps the operand's count of ones
  assert_rot_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (op_q == OP_ROL || op_q == OP_ROR)) |->
      ($countones(result) == $countones(opnd_q)));

  // R9: byte results never carry bits in the upper half
  assert_byte_upper_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !wide_q) |-> (result[DATA_W-1:HALF_W] == '0));

  // R6: a zero-length run leaves the operand as it was
  assert_zero_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (cnt_q == '0 || op_q == OP_NONE)) |-> (result == opnd_q && flag_upd == '0));

endmodule

// File: tb/tb_sr_unit.sv
module tb_sr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  op = '0;
  logic        wide = 1'b1;
  logic [15:0] operand = '0;
  logic [4:0]  count = '0;
  logic [4:0]  flags_in = '0;
  logic        busy, done;
  logic [15:0] result;
  logic [4:0]  flags_out, flag_upd;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sr_unit dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .wide(wide),
    .operand(operand), .count(count), .flags_in(flags_in),
    .busy(busy), .done(done), .result(result),
    .flags_out(flags_out), .flag_upd(flag_upd)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Reference built from the requirements: walk the ring one bit at a time.
  task automatic model(input logic [2:0] o, input logic w, input logic [15:0] a,
                       input logic [4:0] n, input logic [4:0] fi,
                       output logic [15:0] r, output logic [4:0] fo,
                       output logic [4:0] fm);
    int tb = w ? 15 : 7;
    logic [15:0] m = w ? 16'hFFFF : 16'h00FF;
    logic [15:0] v = a & m;
    logic c = fi[0];
    logic om = v[tb];
    logic nc;
    logic [4:0] calc;
    if (n == 0 || o == 3'd7) begin
      r = v; fo = fi; fm = 5'b0;
      return;
    end
    for (int i = 0; i < int'(n); i++) begin
      case (o)
        3'd0: begin c = v[tb]; v = (v << 1) & m; end
        3'd1: begin c = v[0]; v = v >> 1; end
        3'd2: begin nc = v[tb]; c = v[0]; v = v >> 1; v[tb] = nc; end
        3'd3: begin c = v[tb]; v = ((v << 1) & m) | {15'b0, c}; end
        3'd4: begin c = v[0]; v = v >> 1; v[tb] = c; end
        3'd5: begin nc = v[tb]; v = ((v << 1) & m) | {15'b0, c}; c = nc; end
        default: begin nc = v[0]; v = v >> 1; v[tb] = c; c = nc; end
      endcase
    end
    case (o)
      3'd2:       fm = 5'b11101;
      3'd3, 3'd4: fm = 5'b00011;
      default:    fm = 5'b11111;
    endcase
    calc[0] = c;
    calc[2] = ~^v[7:0];
    calc[3] = v[tb];
    calc[4] = (v == 16'h0);
    calc[1] = fi[1];
    if (n == 1) begin
      case (o)
        3'd0, 3'd3, 3'd5: calc[1] = v[tb] ^ c;
        3'd1:             calc[1] = om;
        3'd4, 3'd6:       calc[1] = v[tb] ^ v[tb-1];
        default:          calc[1] = fi[1];
      endcase
    end
    r = v;
    fo = (calc & fm) | (fi & ~fm);
  endtask

  // Issue one request; checks done timing (R10) and returns outputs.
  task automatic run_op(input logic [2:0] o, input logic w, input logic [15:0] a,
                        input logic [4:0] n, input logic [4:0] fi, input string tag,
                        output logic [15:0] r, output logic [4:0] fo, output logic [4:0] fm);
    int lat = (n == 0 || o == 3'd7) ? 0 : int'(n);
    bit ok = 1'b1;
    @(negedge clk);
    op = o; wide = w; operand = a; count = n; flags_in = fi; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int e = 0; e <= lat; e++) begin
      if (done !== (e == lat)) ok = 1'b0;
      if (e < lat && busy !== 1'b1) ok = 1'b0;
      if (e < lat) @(negedge clk);
    end
    chk({tag, " R10"}, "done_timing", {31'b0, ok}, 32'd1);
    r = result; fo = flags_out; fm = flag_upd;
  endtask

  task automatic check_op(input logic [2:0] o, input logic w, input logic [15:0] a,
                          input logic [4:0] n, input logic [4:0] fi, input string tag);
    logic [15:0] r, er;
    logic [4:0] fo, fm, efo, efm;
    run_op(o, w, a, n, fi, tag, r, fo, fm);
    model(o, w, a, n, fi, er, efo, efm);
    chk(tag, "result", {16'b0, r}, {16'b0, er});
    chk(tag, "flags", {27'b0, fo}, {27'b0, efo});
    chk(tag, "mask", {27'b0, fm}, {27'b0, efm});
  endtask

  task automatic check_lit(input logic [2:0] o, input logic w, input logic [15:0] a,
                           input logic [4:0] n, input logic [4:0] fi, input string tag,
                           input logic [15:0] er, input logic [4:0] efo, input logic [4:0] efm);
    logic [15:0] r;
    logic [4:0] fo, fm;
    run_op(o, w, a, n, fi, tag, r, fo, fm);
    chk(tag, "lit_result", {16'b0, r}, {16'b0, er});
    chk(tag, "lit_flags", {27'b0, fo}, {27'b0, efo});
    chk(tag, "lit_mask", {27'b0, fm}, {27'b0, efm});
  endtask

  task automatic test_reset();
    chk("R12", "busy", {31'b0, busy}, 32'd0);
    chk("R12", "done", {31'b0, done}, 32'd0);
    chk("R12", "result", {16'b0, result}, 32'd0);
    chk("R12", "flag_upd", {27'b0, flag_upd}, 32'd0);
  endtask

  task automatic test_shl();
    check_lit(3'd0, 1'b1, 16'h8001, 5'd1, 5'b00000, "R1", 16'h0002, 5'b00011, 5'b11111);
    check_op(3'd0, 1'b1, 16'h1234, 5'd4, 5'b00010, "R1");
    check_op(3'd0, 1'b1, 16'hFFFF, 5'd17, 5'b00001, "R1");
  endtask

  task automatic test_shr();
    check_op(3'd1, 1'b1, 16'h8421, 5'd3, 5'b00000, "R2");
    check_op(3'd1, 1'b1, 16'h0001, 5'd1, 5'b11111, "R2");
  endtask

  task automatic test_sar();
    check_lit(3'd2, 1'b0, 16'h0081, 5'd2, 5'b00010, "R3", 16'h00E0, 5'b01010, 5'b11101);
    check_op(3'd2, 1'b1, 16'h8000, 5'd15, 5'b00000, "R3");
    check_op(3'd2, 1'b1, 16'h4000, 5'd1, 5'b00010, "R3");
  endtask

  task automatic test_rot();
    check_lit(3'd4, 1'b1, 16'h0001, 5'd1, 5'b00000, "R4", 16'h8000, 5'b00011, 5'b00011);
    check_op(3'd3, 1'b1, 16'hC003, 5'd5, 5'b11100, "R4");
    check_op(3'd4, 1'b0, 16'h00A5, 5'd3, 5'b00000, "R4");
  endtask

  task automatic test_rcx();
    check_lit(3'd5, 1'b0, 16'h0080, 5'd9, 5'b00001, "R5", 16'h0080, 5'b01001, 5'b11111);
    check_op(3'd6, 1'b1, 16'h0003, 5'd2, 5'b00001, "R5");
    check_op(3'd5, 1'b1, 16'h8001, 5'd31, 5'b00000, "R5");
  endtask

  task automatic test_zero();
    check_lit(3'd0, 1'b1, 16'hBEEF, 5'd0, 5'b10110, "R6", 16'hBEEF, 5'b10110, 5'b00000);
    check_lit(3'd7, 1'b1, 16'h1357, 5'd12, 5'b01001, "R6", 16'h1357, 5'b01001, 5'b00000);
  endtask

  task automatic test_of_one();
    check_op(3'd0, 1'b1, 16'h4000, 5'd1, 5'b00000, "R7");
    check_op(3'd1, 1'b1, 16'h8000, 5'd1, 5'b00000, "R7");
    check_op(3'd5, 1'b0, 16'h0040, 5'd1, 5'b00001, "R7");
    check_op(3'd6, 1'b1, 16'h0000, 5'd1, 5'b00001, "R7");
    check_op(3'd0, 1'b1, 16'h4000, 5'd2, 5'b00010, "R7");
  endtask

  task automatic test_pf_sf_zf();
    check_op(3'd0, 1'b1, 16'h0180, 5'd1, 5'b00000, "R8");
    check_op(3'd1, 1'b1, 16'h0001, 5'd1, 5'b00000, "R8");
    check_op(3'd0, 1'b0, 16'h0003, 5'd6, 5'b00000, "R8");
  endtask

  task automatic test_byte();
    check_op(3'd0, 1'b0, 16'hAB81, 5'd1, 5'b00000, "R9");
    check_op(3'd3, 1'b0, 16'hFF0F, 5'd4, 5'b00000, "R9");
  endtask

  task automatic test_flag_pass();
    check_op(3'd3, 1'b1, 16'h00F0, 5'd2, 5'b11100, "R11");
    check_op(3'd2, 1'b1, 16'h0F00, 5'd3, 5'b00010, "R11");
  endtask

  task automatic test_busy_ignore();
    logic [15:0] er;
    logic [4:0] efo, efm;
    bit ok = 1'b1;
    model(3'd0, 1'b1, 16'h1234, 5'd4, 5'b00000, er, efo, efm);
    @(negedge clk);
    op = 3'd0; wide = 1'b1; operand = 16'h1234; count = 5'd4; flags_in = 5'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    op = 3'd1; operand = 16'hFFFF; count = 5'd0; flags_in = 5'b11111; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (done !== 1'b0) ok = 1'b0;
    @(negedge clk);
    if (done !== 1'b0) ok = 1'b0;
    @(negedge clk);
    if (done !== 1'b1) ok = 1'b0;
    chk("R10", "ignored_start_timing", {31'b0, ok}, 32'd1);
    chk("R10", "ignored_start_result", {16'b0, result}, {16'b0, er});
    chk("R10", "ignored_start_flags", {27'b0, flags_out}, {27'b0, efo});
    @(negedge clk);
    chk("R10", "no_second_done", {31'b0, done}, 32'd0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R10 watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_shl();
    test_shr();
    test_sar();
    test_rot();
    test_rcx();
    test_zero();
    test_of_one();
    test_pf_sf_zf();
    test_byte();
    test_flag_pass();
    test_busy_ignore();
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule